// File: doc/BRIEF.md
# Two-Master Spoke Crossbar Router

This block connects two bus masters, a processor port and a DMA port, to eight peripheral spokes. Each master request carries an address, a write flag, a size code and write data. The spoke is taken from three address bits, so the two masters work in parallel whenever they aim at different spokes. When both aim at the same spoke, the processor port wins and the DMA port is held with its ready signal low until the spoke is free.

Spokes have no wait states. A request is accepted in the cycle where valid and ready are both high, and the spoke sees its strobe in that same cycle. The spoke answers a read from a register one cycle later. The router returns that word to the master that issued the read, with a registered read-valid pulse. Spoke 5 is reserved: requests to it are accepted and arbitrated as usual, but no spoke strobe is raised and reads return zero.

Top module: `dual_master_spoke_router`

## Requirements
- R1: The spoke index is address bits [27:25]. Bits [31:28] have no effect on routing. The spoke receives address bits [24:0].
- R2: A spoke strobe is raised only for the master granted that spoke. At most two spoke strobes are high in any cycle. The spoke's write flag, address, byte enables and write data come from the granted master.
- R3: A processor request is accepted in the cycle it is presented (processor ready equals processor valid), whatever the spoke and whatever the DMA port does.
- R4: When both masters request the same spoke in a cycle, DMA ready is low and the DMA request stays pending. It is accepted in the first cycle in which the processor is not requesting that spoke.
- R5: When the two masters request different spokes, both are accepted in the same cycle.
- R6: Spoke 5 is reserved. A request to it is accepted, spoke 5's strobe never rises, and a read from it returns zero.
- R7: The size code 0, 1, 2, 3 means a transfer of 1, 2, 3, 4 bytes. The byte enables cover the lanes from address bits [1:0] upward for that many bytes. Lanes beyond lane 3 are dropped.
- R8: A read accepted in cycle t raises that master's read-valid in cycle t+1. The read data is the word from the spoke that was granted, with lanes outside the byte enables forced to zero. An accepted write raises no read-valid.
- R9: A master may present a new request in the cycle its read data returns. A DMA read on one spoke can be followed, in the next cycle, by a DMA write to another spoke, with no idle cycle between them.
- R10: After synchronous reset, with no request presented, both read-valid outputs, both ready outputs and all spoke strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | Processor request is a write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Processor size code (bytes minus one) |
| cpu_wdata | input | 32 | Processor write data, lane aligned |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 32 | Processor read data |
| dma_valid | input | 1 | DMA request present |
| dma_write | input | 1 | DMA request is a write |
| dma_addr | input | 32 | DMA byte address |
| dma_size | input | 2 | DMA size code (bytes minus one) |
| dma_wdata | input | 32 | DMA write data, lane aligned |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |
| spk_valid | output | 8 | Per-spoke strobe |
| spk_write | output | 8 | Per-spoke write flag |
| spk_addr | output | 200 | Per-spoke offset address, 25 bits each |
| spk_be | output | 32 | Per-spoke byte enables, 4 bits each |
| spk_wdata | output | 256 | Per-spoke write data, 32 bits each |
| spk_rdata | input | 256 | Per-spoke registered read data, 32 bits each |

## Verification
The hardest case to reach from the ports is a DMA request that waits several cycles behind a run of processor transfers on the same spoke and then reads data the processor has just written. Ordering errors show up only in that case. The bench starts both masters at the same clock edge from parallel drivers. The processor side issues back-to-back transfers to one spoke while the DMA side aims at the same spoke. The bench checks the exact number of stall cycles, and the scoreboard checks that the delayed DMA read returns the processor's newest value. A DMA read followed at once by a DMA write on another spoke exercises the overlap of a returning read with a new request.

// File: rtl/dmsr_pkg.sv
package dmsr_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B3 = 2'd2,
    SZ_B4 = 2'd3
  } xfer_size_e;

  // Number of bytes moved for a size code.
  function automatic int size_bytes(input logic [1:0] sz);
    xfer_size_e e;
    e = xfer_size_e'(sz);
    case (e)
      SZ_B1:   return 1;
      SZ_B2:   return 2;
      SZ_B3:   return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/dmsr_decode.sv
module dmsr_decode #(
  parameter int AW      = 32,
  parameter int SEL_LSB = 25,
  parameter int NSPOKE  = 8,
  parameter int BEW     = 4
) (
  input  logic                       valid,
  input  logic [AW-1:0]              addr,
  input  logic [1:0]                 size,
  output logic [$clog2(NSPOKE)-1:0]  sel,
  output logic [NSPOKE-1:0]          req,
  output logic [BEW-1:0]             be
);
  import dmsr_pkg::*;

  localparam int SEL_W = $clog2(NSPOKE);
  localparam int OFF_W = $clog2(BEW);

  logic [OFF_W-1:0] off;
  logic             unused_bits;

  assign sel = addr[SEL_LSB +: SEL_W];
  assign off = addr[OFF_W-1:0];
  assign unused_bits = ^{addr[AW-1:SEL_LSB+SEL_W], addr[SEL_LSB-1:OFF_W]};

  always_comb begin
    for (int s = 0; s < NSPOKE; s++) begin
      req[s] = valid && (sel == SEL_W'(s));
    end
  end

  always_comb begin
    int nb;
    nb = size_bytes(size);
    for (int b = 0; b < BEW; b++) begin
      be[b] = (b >= int'(off)) && (b < int'(off) + nb);
    end
  end

endmodule

// File: rtl/dmsr_arb.sv
module dmsr_arb #(
  parameter bit CPU_FIRST = 1'b1
) (
  input  logic req_c,
  input  logic req_d,
  output logic gnt_c,
  output logic gnt_d
);
  if (CPU_FIRST) begin : g_cpu_first
    assign gnt_c = req_c;
    assign gnt_d = req_d && !req_c;
  end else begin : g_dma_first
    assign gnt_d = req_d;
    assign gnt_c = req_c && !req_d;
  end
endmodule

// File: rtl/dmsr_return.sv
module dmsr_return #(
  parameter int NSPOKE     = 8,
  parameter int DW         = 32,
  parameter int RSVD_SPOKE = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic                      write,
  input  logic [$clog2(NSPOKE)-1:0] sel,
  input  logic [DW/8-1:0]           be,
  input  logic [NSPOKE*DW-1:0]      spk_rdata,
  output logic                      rvalid,
  output logic [DW-1:0]             rdata
);
  localparam int SEL_W = $clog2(NSPOKE);
  localparam int BEW   = DW / 8;

  logic             rvalid_q;
  logic [SEL_W-1:0] sel_q;
  logic [BEW-1:0]   be_q;
  logic [DW-1:0]    word;
  logic [DW-1:0]    lane_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      sel_q    <= '0;
      be_q     <= '0;
    end else begin
      rvalid_q <= accept && !write;
      if (accept && !write) begin
        sel_q <= sel;
        be_q  <= be;
      end
    end
  end

  always_comb begin
    word = spk_rdata[int'(sel_q)*DW +: DW];
    if (sel_q == SEL_W'(RSVD_SPOKE)) word = '0;
    for (int b = 0; b < BEW; b++) begin
      lane_mask[b*8 +: 8] = {8{be_q[b]}};
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rvalid_q ? (word & lane_mask) : '0;

endmodule

// File: rtl/dual_master_spoke_router.sv
module dual_master_spoke_router #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NSPOKE     = 8,
  parameter int SEL_LSB    = 25,
  parameter int RSVD_SPOKE = 5,
  parameter bit CPU_FIRST  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_valid,
  input  logic                      cpu_write,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [1:0]                cpu_size,
  input  logic [DW-1:0]             cpu_wdata,
  output logic                      cpu_ready,
  output logic                      cpu_rvalid,
  output logic [DW-1:0]             cpu_rdata,
  input  logic                      dma_valid,
  input  logic                      dma_write,
  input  logic [AW-1:0]             dma_addr,
  input  logic [1:0]                dma_size,
  input  logic [DW-1:0]             dma_wdata,
  output logic                      dma_ready,
  output logic                      dma_rvalid,
  output logic [DW-1:0]             dma_rdata,
  output logic [NSPOKE-1:0]         spk_valid,
  output logic [NSPOKE-1:0]         spk_write,
  output logic [NSPOKE*SEL_LSB-1:0] spk_addr,
  output logic [NSPOKE*(DW/8)-1:0]  spk_be,
  output logic [NSPOKE*DW-1:0]      spk_wdata,
  input  logic [NSPOKE*DW-1:0]      spk_rdata
);
  localparam int SEL_W  = $clog2(NSPOKE);
  localparam int BEW    = DW / 8;
  localparam int SPK_AW = SEL_LSB;

  logic [SEL_W-1:0]  cpu_sel, dma_sel;
  logic [NSPOKE-1:0] cpu_req, dma_req;
  logic [NSPOKE-1:0] cpu_gnt, dma_gnt;
  logic [BEW-1:0]    cpu_be, dma_be;

  dmsr_decode #(.AW(AW), .SEL_LSB(SEL_LSB), .NSPOKE(NSPOKE), .BEW(BEW)) u_dec_cpu (
    .valid(cpu_valid), .addr(cpu_addr), .size(cpu_size),
    .sel(cpu_sel), .req(cpu_req), .be(cpu_be)
  );

  dmsr_decode #(.AW(AW), .SEL_LSB(SEL_LSB), .NSPOKE(NSPOKE), .BEW(BEW)) u_dec_dma (
    .valid(dma_valid), .addr(dma_addr), .size(dma_size),
    .sel(dma_sel), .req(dma_req), .be(dma_be)
  );

  for (genvar s = 0; s < NSPOKE; s++) begin : g_spoke
    dmsr_arb #(.CPU_FIRST(CPU_FIRST)) u_arb (
      .req_c(cpu_req[s]), .req_d(dma_req[s]),
      .gnt_c(cpu_gnt[s]), .gnt_d(dma_gnt[s])
    );

    if (s == RSVD_SPOKE) begin : g_rsvd
      assign spk_valid[s]                 = 1'b0;
      assign spk_write[s]                 = 1'b0;
      assign spk_addr[s*SPK_AW +: SPK_AW] = '0;
      assign spk_be[s*BEW +: BEW]         = '0;
      assign spk_wdata[s*DW +: DW]        = '0;
    end else begin : g_live
      assign spk_valid[s] = cpu_gnt[s] || dma_gnt[s];
      assign spk_write[s] = cpu_gnt[s] ? cpu_write : (dma_gnt[s] && dma_write);
      assign spk_addr[s*SPK_AW +: SPK_AW] =
        cpu_gnt[s] ? cpu_addr[SPK_AW-1:0] :
        dma_gnt[s] ? dma_addr[SPK_AW-1:0] : '0;
      assign spk_be[s*BEW +: BEW] =
        cpu_gnt[s] ? cpu_be : dma_gnt[s] ? dma_be : '0;
      assign spk_wdata[s*DW +: DW] =
        cpu_gnt[s] ? cpu_wdata : dma_gnt[s] ? dma_wdata : '0;
    end
  end

  assign cpu_ready = |cpu_gnt;
  assign dma_ready = |dma_gnt;

  dmsr_return #(.NSPOKE(NSPOKE), .DW(DW), .RSVD_SPOKE(RSVD_SPOKE)) u_ret_cpu (
    .clk(clk), .rst(rst), .accept(cpu_ready), .write(cpu_write),
    .sel(cpu_sel), .be(cpu_be), .spk_rdata(spk_rdata),
    .rvalid(cpu_rvalid), .rdata(cpu_rdata)
  );

  dmsr_return #(.NSPOKE(NSPOKE), .DW(DW), .RSVD_SPOKE(RSVD_SPOKE)) u_ret_dma (
    .clk(clk), .rst(rst), .accept(dma_ready), .write(dma_write),
    .sel(dma_sel), .be(dma_be), .spk_rdata(spk_rdata),
    .rvalid(dma_rvalid), .rdata(dma_rdata)
  );

endmodule

// File: rtl/dmsr_checker.sv
module dmsr_checker #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NSPOKE     = 8,
  parameter int SEL_LSB    = 25,
  parameter int RSVD_SPOKE = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_write,
  input logic [AW-1:0]     cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic [DW-1:0]     cpu_rdata,
  input logic              dma_valid,
  input logic [AW-1:0]     dma_addr,
  input logic              dma_ready,
  input logic [NSPOKE-1:0] spk_valid
);
  localparam int SEL_W = $clog2(NSPOKE);

  logic [SEL_W-1:0] c_sel, d_sel;
  logic             same;
  assign c_sel = cpu_addr[SEL_LSB +: SEL_W];
  assign d_sel = dma_addr[SEL_LSB +: SEL_W];
  assign same  = cpu_valid && dma_valid && (c_sel == d_sel);

  AST_CPU_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |-> cpu_ready); // R3

  AST_DMA_YIELD: assert property (@(posedge clk) disable iff (rst)
    same |-> !dma_ready); // R4

  AST_DMA_PARALLEL: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && !same) |-> dma_ready); // R5

  AST_SPOKE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(spk_valid) <= 2); // R2

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !cpu_write) |=> cpu_rvalid); // R8

  AST_RVALID_CAUSED: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(cpu_valid && cpu_ready && !cpu_write)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_write && c_sel == SEL_W'(RSVD_SPOKE)) |=> (cpu_rdata == '0)); // R6

endmodule

bind dual_master_spoke_router dmsr_checker #(
  .AW(AW), .DW(DW), .NSPOKE(NSPOKE), .SEL_LSB(SEL_LSB), .RSVD_SPOKE(RSVD_SPOKE)
) u_chk (
  .clk(clk), .rst(rst),
  .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
  .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_ready(dma_ready),
  .spk_valid(spk_valid)
);

// File: tb/dual_master_spoke_router_tb.sv
`timescale 1ns/1ps
module dual_master_spoke_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cpu_valid = 0, cpu_write = 0, dma_valid = 0, dma_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, dma_addr = 0, dma_wdata = 0;
  logic [1:0]  cpu_size = 0, dma_size = 0;
  logic        cpu_ready, cpu_rvalid, dma_ready, dma_rvalid;
  logic [31:0] cpu_rdata, dma_rdata;
  logic [7:0]  spk_valid, spk_write;
  logic [199:0] spk_addr;
  logic [31:0] spk_be;
  logic [255:0] spk_wdata, spk_rdata;

  dual_master_spoke_router u_dut (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dma_valid(dma_valid), .dma_write(dma_write), .dma_addr(dma_addr),
    .dma_size(dma_size), .dma_wdata(dma_wdata), .dma_ready(dma_ready),
    .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .spk_valid(spk_valid), .spk_write(spk_write), .spk_addr(spk_addr),
    .spk_be(spk_be), .spk_wdata(spk_wdata), .spk_rdata(spk_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] ref_mem [8][16];
  logic [31:0] smem [8][16];
  logic [31:0] srd [8];
  logic [31:0] q_cpu[$], q_dma[$];

  function automatic logic [31:0] pat(int s, int w);
    return {8'(s * 16 + w), 8'hC3, 8'(w), 8'(s)};
  endfunction

  function automatic logic [3:0] lanes(logic [1:0] off, logic [1:0] sz);
    logic [3:0] m;
    for (int b = 0; b < 4; b++) m[b] = (b >= int'(off)) && (b <= int'(off) + int'(sz));
    return m;
  endfunction

  function automatic logic [31:0] expand(logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] mk(int sp, int w, int off, logic [3:0] hi);
    return {hi, 3'(sp), 19'd0, 4'(w), 2'(off)};
  endfunction

  // Peripheral model: one-cycle registered read, byte-lane writes.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int s = 0; s < 8; s++) begin
        srd[s] <= '0;
        for (int w = 0; w < 16; w++) smem[s][w] <= pat(s, w);
      end
    end else begin
      for (int s = 0; s < 8; s++) begin
        if (spk_valid[s]) begin
          if (spk_write[s]) begin
            for (int b = 0; b < 4; b++)
              if (spk_be[s*4 + b])
                smem[s][spk_addr[s*25 + 2 +: 4]][b*8 +: 8] <= spk_wdata[s*32 + b*8 +: 8];
          end else begin
            srd[s] <= smem[s][spk_addr[s*25 + 2 +: 4]];
          end
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 8; s++)
      spk_rdata[s*32 +: 32] = (s == 5) ? 32'hA5A5_A5A5 : srd[s];
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one request, waits for acceptance, records expectation.
  task automatic xfer(input int m, input bit wr, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output int waits, output int at);
    logic rdy;
    int sp, w;
    logic [31:0] msk;
    @(negedge clk);
    if (m == 0) begin
      cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    end else begin
      dma_valid = 1; dma_write = wr; dma_addr = a; dma_size = sz; dma_wdata = wd;
    end
    waits = 0;
    forever begin
      #1;
      rdy = (m == 0) ? cpu_ready : dma_ready;
      @(posedge clk);
      if (rdy) break;
      waits++;
      @(negedge clk);
    end
    at = cyc;
    sp = int'(a[27:25]);
    w = int'(a[5:2]);
    msk = expand(lanes(a[1:0], sz));
    if (wr) begin
      if (sp != 5) ref_mem[sp][w] = (ref_mem[sp][w] & ~msk) | (wd & msk);
    end else begin
      if (m == 0) q_cpu.push_back((sp == 5) ? 32'h0 : (ref_mem[sp][w] & msk));
      else        q_dma.push_back((sp == 5) ? 32'h0 : (ref_mem[sp][w] & msk));
    end
    #1;
    if (m == 0) cpu_valid = 0; else dma_valid = 0;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_rvalid) begin
        if (q_cpu.size() == 0) check(0, "R8 cpu unexpected rvalid", {32'h0, cpu_rdata}, 64'h0);
        else begin
          logic [31:0] e;
          e = q_cpu.pop_front();
          check(cpu_rdata == e, "R8 cpu rdata", {32'h0, cpu_rdata}, {32'h0, e});
        end
      end
      if (dma_rvalid) begin
        if (q_dma.size() == 0) check(0, "R8 dma unexpected rvalid", {32'h0, dma_rdata}, 64'h0);
        else begin
          logic [31:0] e;
          e = q_dma.pop_front();
          check(dma_rdata == e, "R8 dma rdata", {32'h0, dma_rdata}, {32'h0, e});
        end
      end
      if ((cpu_valid && cpu_addr[27:25] == 3'd5) || (dma_valid && dma_addr[27:25] == 3'd5))
        check(!spk_valid[5], "R6 reserved strobe", {63'h0, spk_valid[5]}, 64'h0);
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  initial begin
    int wa, wb, ta, tb;
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 16; w++) ref_mem[s][w] = pat(s, w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R10 reset state
    check(!cpu_rvalid && !dma_rvalid, "R10 rvalid", {62'h0, cpu_rvalid, dma_rvalid}, 64'h0);
    check(!cpu_ready && !dma_ready && spk_valid == 8'h0, "R10 ready/strobe",
          {54'h0, cpu_ready, dma_ready, spk_valid}, 64'h0);

    // R1/R2/R7: direct drive, upper bits set
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = 32'hF600_0014; cpu_size = 2'd3; cpu_wdata = 32'hCAFE_F00D;
    #1;
    check(spk_valid == 8'h08, "R1 spoke select", {56'h0, spk_valid}, 64'h08);
    check(spk_addr[3*25 +: 25] == 25'h14, "R1 offset", {39'h0, spk_addr[3*25 +: 25]}, 64'h14);
    check(spk_wdata[3*32 +: 32] == 32'hCAFE_F00D && spk_write[3], "R2 write path",
          {32'h0, spk_wdata[3*32 +: 32]}, 64'hCAFE_F00D);
    @(posedge clk);
    ref_mem[3][5] = 32'hCAFE_F00D;
    #1 cpu_valid = 0;
    @(negedge clk);
    check(!cpu_rvalid, "R8 write no rvalid", {63'h0, cpu_rvalid}, 64'h0);
    xfer(0, 0, mk(3, 5, 0, 4'h0), 2'd3, 0, wa, ta);     // R1 read back without upper bits

    // R7 lane enables for a 3-byte write at offset 1
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = mk(1, 7, 1, 4'h0); cpu_size = 2'd2; cpu_wdata = 32'hABCD_EF00;
    #1;
    check(spk_be[1*4 +: 4] == 4'hE, "R7 byte enables", {60'h0, spk_be[4 +: 4]}, 64'hE);
    @(posedge clk);
    ref_mem[1][7] = (ref_mem[1][7] & 32'h0000_00FF) | 32'hABCD_EF00;
    #1 cpu_valid = 0;
    xfer(0, 0, mk(1, 7, 0, 4'h0), 2'd3, 0, wa, ta);

    // R8 read every spoke, R6 spoke 5 returns zero
    for (int s = 0; s < 8; s++) xfer(0, 0, mk(s, s, 0, 4'h0), 2'd3, 0, wa, ta);
    xfer(0, 1, mk(5, 2, 0, 4'h0), 2'd3, 32'h1234_5678, wa, ta);
    xfer(1, 0, mk(5, 2, 0, 4'h0), 2'd3, 0, wa, ta);

    // R7 sizes and lane dropping
    xfer(0, 1, mk(1, 2, 0, 4'h0), 2'd3, 32'h1122_3344, wa, ta);
    xfer(0, 1, mk(1, 2, 2, 4'h0), 2'd0, 32'h00AA_0000, wa, ta);
    xfer(0, 0, mk(1, 2, 1, 4'h0), 2'd2, 0, wa, ta);
    xfer(0, 0, mk(1, 2, 3, 4'h0), 2'd1, 0, wa, ta);
    xfer(0, 1, mk(1, 2, 0, 4'h0), 2'd2, 32'hFFFF_FFFF, wa, ta);
    xfer(1, 0, mk(1, 2, 0, 4'h0), 2'd3, 0, wa, ta);

    // R5 parallel on different spokes
    fork
      xfer(0, 0, mk(0, 1, 0, 4'h0), 2'd3, 0, wa, ta);
      xfer(1, 0, mk(4, 2, 0, 4'h0), 2'd3, 0, wb, tb);
    join
    check(wa == 0 && wb == 0 && ta == tb, "R5 parallel reads", {wa[31:0], wb[31:0]}, 64'h0);
    fork
      xfer(0, 1, mk(6, 0, 0, 4'h0), 2'd3, 32'h6666_0000, wa, ta);
      xfer(1, 1, mk(7, 0, 0, 4'h0), 2'd3, 32'h7777_0000, wb, tb);
    join
    check(wa == 0 && wb == 0 && ta == tb, "R5 parallel writes", {wa[31:0], wb[31:0]}, 64'h0);

    // R4 conflict: DMA reads what CPU writes first
    fork
      xfer(0, 1, mk(6, 3, 0, 4'h0), 2'd3, 32'hBEEF_0006, wa, ta);
      xfer(1, 0, mk(6, 3, 0, 4'h0), 2'd3, 0, wb, tb);
    join
    check(wa == 0, "R3 cpu not stalled", {32'h0, wa[31:0]}, 64'h0);
    check(wb == 1, "R4 dma stall count", {32'h0, wb[31:0]}, 64'h1);

    // R4 DMA waits behind a run of three CPU transfers
    fork
      begin
        int w1, t1;
        xfer(0, 1, mk(7, 9, 0, 4'h0), 2'd3, 32'h0000_9999, w1, t1);
        xfer(0, 0, mk(7, 1, 0, 4'h0), 2'd3, 0, w1, t1);
        xfer(0, 1, mk(7, 9, 0, 4'h0), 2'd3, 32'h0000_AAAA, w1, t1);
      end
      xfer(1, 0, mk(7, 9, 0, 4'h0), 2'd3, 0, wb, tb);
    join
    check(wb == 3, "R4 dma long stall", {32'h0, wb[31:0]}, 64'h3);

    // R9 DMA read then write on another spoke, back to back
    xfer(1, 0, mk(0, 4, 0, 4'h0), 2'd3, 0, wa, ta);
    xfer(1, 1, mk(2, 4, 0, 4'h0), 2'd3, 32'h5566_7788, wb, tb);
    check(wa == 0 && wb == 0 && tb == ta + 1, "R9 back to back", {32'h0, tb[31:0]}, {32'h0, ta[31:0] + 32'd1});
    xfer(0, 0, mk(2, 4, 0, 4'h0), 2'd3, 0, wa, ta);

    repeat (4) @(negedge clk);
    check(q_cpu.size() == 0 && q_dma.size() == 0, "R8 all reads returned",
          {32'(q_cpu.size()), 32'(q_dma.size())}, 64'h0);
    finish_run();
  end
endmodule